// File: doc/BRIEF.md
# Address-Event Input Decoder

This block terminates an asynchronous four-phase request/acknowledge link that carries 17-bit event addresses into a neuromorphic core. The request line is brought into the local clock domain through two flip-flops. Once it is seen high, the address is captured and sorted into one of seven event kinds. The block then presents a decoded command to the controller or scheduler behind it.

The command carries a kind code, the upper and lower neuron fields, and the inline weight, sign and leak bits of virtual events. It also carries a strobe for kinds that are queued in the scheduler, and the nominal number of processing cycles for that kind. The nominal cycle count is there for test visibility.

The acknowledge stays low until the downstream logic reports completion. It then stays high until the synchronized request falls. An address that matches no kind raises no command and is acknowledged at once.

Top module: `aer_event_decoder`

## Requirements
- R1: The request passes through two flip-flops. When `ev_req` rises just before clock edge k, `cmd_valid` (or `ev_ack` for a dropped address) is low after edge k+1 and high after edge k+2.
- R2: When address bit 16 is 1, the kind is synapse (code 0), `cmd_hi` equals bits 15:8 (source neuron), `cmd_lo` equals bits 7:0 (target neuron), and `cmd_cycles` is 2.
- R3: With bit 16 at 0, a low byte of 8'hFF gives one-neuron time reference (code 1, 2 cycles), and 8'h7F gives all-neuron time reference (code 2, 512 cycles). `cmd_hi` carries bits 15:8.
- R4: With bit 16 at 0, a low byte of 8'h80 gives one-neuron bistability (code 3, 128 cycles), and 8'h00 gives all-synapse bistability (code 4, 32768 cycles).
- R5: With bit 16 at 0, a low byte of 8'h07 gives a spike event (code 5, 1 cycle), and `sched_push` is high together with `cmd_valid`.
- R6: With bit 16 at 0, any other low byte whose bits 2:0 are 3'b001 gives a virtual event (code 6, 1 cycle) with `sched_push` high. Its fields are: `virt_weight` equals bits 7:5, `virt_inhib` equals bit 4 (1 means inhibitory), and `virt_leak` equals bit 3. The exact-match codes take priority over this pattern.
- R7: Any other low byte with bit 16 at 0 is dropped. No `cmd_valid` pulse is issued, `cmd_type` becomes 7, `cmd_cycles` becomes 0, and `ev_ack` rises without waiting for `done`.
- R8: `cmd_valid` is a single-cycle pulse. `ev_ack` stays low after the pulse until `done` is seen, and rises on the edge after `done`.
- R9: `ev_ack` stays high while the request is high, and no new command is issued during that time. `ev_ack` falls on the third edge after `ev_req` falls.
- R10: After reset, `ev_ack`, `cmd_valid` and `sched_push` are low, `cmd_type` is 7, and `cmd_cycles` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| ev_addr | input | 17 | Event address from the link |
| ev_req | input | 1 | Asynchronous request |
| ev_ack | output | 1 | Acknowledge to the link |
| done | input | 1 | Downstream completion pulse |
| cmd_valid | output | 1 | One-cycle command strobe |
| sched_push | output | 1 | Command is queued in the scheduler |
| cmd_type | output | 3 | Event kind code (7 = dropped/none) |
| cmd_hi | output | 8 | Address bits 15:8 |
| cmd_lo | output | 8 | Address bits 7:0 |
| virt_weight | output | 3 | Virtual event weight |
| virt_inhib | output | 1 | Virtual event sign, 1 = inhibitory |
| virt_leak | output | 1 | Virtual event leak flag |
| cmd_cycles | output | 16 | Nominal processing cycles for the kind |

## Verification
A wrong classification shows on `cmd_type`, `cmd_cycles` and `sched_push` on the very cycle of the `cmd_valid` pulse, two edges after the synchronized request. A handshake state stuck in the wrong place shows within one edge as one of three faults: an acknowledge with no preceding `done`, a second command during the acknowledge, or an acknowledge that misses its fall three edges after the request drops. The bench sweeps all 256 low bytes with bit 16 clear and a spread of synapse addresses, and checks each against a classification written directly from the requirements.

// File: rtl/aer_event_decoder.sv
module aer_event_decoder #(
  parameter int NEUR_W = 8,
  parameter int CNT_W  = 2 * NEUR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NEUR_W:0]     ev_addr,
  input  logic                  ev_req,
  output logic                  ev_ack,
  input  logic                  done,
  output logic                  cmd_valid,
  output logic                  sched_push,
  output logic [2:0]            cmd_type,
  output logic [NEUR_W-1:0]     cmd_hi,
  output logic [NEUR_W-1:0]     cmd_lo,
  output logic [2:0]            virt_weight,
  output logic                  virt_inhib,
  output logic                  virt_leak,
  output logic [CNT_W-1:0]      cmd_cycles
);
  localparam int ADDR_W = 2 * NEUR_W + 1;
  localparam int NN     = 1 << NEUR_W;

  localparam logic [2:0] K_SYN   = 3'd0;
  localparam logic [2:0] K_TREF1 = 3'd1;
  localparam logic [2:0] K_TREFA = 3'd2;
  localparam logic [2:0] K_BIST1 = 3'd3;
  localparam logic [2:0] K_BISTA = 3'd4;
  localparam logic [2:0] K_SPIKE = 3'd5;
  localparam logic [2:0] K_VIRT  = 3'd6;
  localparam logic [2:0] K_NONE  = 3'd7;

  localparam logic [CNT_W-1:0] C_TREFA = CNT_W'(2 * NN);
  localparam logic [CNT_W-1:0] C_BIST1 = CNT_W'(NN / 2);
  localparam logic [CNT_W-1:0] C_BISTA = CNT_W'((NN * NN) / 2);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_ACK} st_t;
  st_t st;

  logic req_m, req_s;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0] type_q, dec;
  logic [7:0] lo;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_m <= 1'b0;
      req_s <= 1'b0;
    end else begin
      req_m <= ev_req;
      req_s <= req_m;
    end

  assign lo = ev_addr[7:0];

  always_comb begin
    if (ev_addr[ADDR_W-1])   dec = K_SYN;
    else if (lo == 8'hFF)    dec = K_TREF1;
    else if (lo == 8'h7F)    dec = K_TREFA;
    else if (lo == 8'h80)    dec = K_BIST1;
    else if (lo == 8'h00)    dec = K_BISTA;
    else if (lo == 8'h07)    dec = K_SPIKE;
    else if (lo[2:0] == 3'b001) dec = K_VIRT;
    else                     dec = K_NONE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      type_q <= K_NONE;
    end else begin
      case (st)
        S_IDLE:  if (req_s) begin
                   addr_q <= ev_addr;
                   type_q <= dec;
                   st     <= (dec == K_NONE) ? S_ACK : S_ISSUE;
                 end
        S_ISSUE: st <= done ? S_ACK : S_WAIT;
        S_WAIT:  if (done) st <= S_ACK;
        S_ACK:   if (!req_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  always_comb
    case (type_q)
      K_SYN, K_TREF1:   cmd_cycles = CNT_W'(2);
      K_TREFA:          cmd_cycles = C_TREFA;
      K_BIST1:          cmd_cycles = C_BIST1;
      K_BISTA:          cmd_cycles = C_BISTA;
      K_SPIKE, K_VIRT:  cmd_cycles = CNT_W'(1);
      default:          cmd_cycles = '0;
    endcase

  assign ev_ack      = (st == S_ACK);
  assign cmd_valid   = (st == S_ISSUE);
  assign sched_push  = cmd_valid && (type_q == K_SPIKE || type_q == K_VIRT);
  assign cmd_type    = type_q;
  assign cmd_hi      = addr_q[ADDR_W-2:NEUR_W];
  assign cmd_lo      = addr_q[NEUR_W-1:0];
  assign virt_weight = addr_q[7:5];
  assign virt_inhib  = addr_q[4];
  assign virt_leak   = addr_q[3];
endmodule

module aer_event_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_s,
  input logic       ev_ack,
  input logic       done,
  input logic       cmd_valid,
  input logic       sched_push,
  input logic [2:0] cmd_type
);
  a_r5_push_only_queued_kinds: assert property (@(posedge clk) disable iff (!rst_n)
    sched_push |-> (cmd_valid && (cmd_type == 3'd5 || cmd_type == 3'd6)));
  a_r7_no_cmd_for_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_type != 3'd7);
  a_r8_ack_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_ack) |-> ($past(done) || cmd_type == 3'd7));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r8_valid_ack_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && ev_ack));
  a_r9_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack && req_s) |=> ev_ack);
  a_r9_no_accept_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> !cmd_valid);
endmodule

bind aer_event_decoder aer_event_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_s(req_s), .ev_ack(ev_ack), .done(done),
  .cmd_valid(cmd_valid), .sched_push(sched_push), .cmd_type(cmd_type)
);

// File: tb/aer_event_decoder_tb.sv
module aer_event_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [16:0] ev_addr = '0;
  logic ev_req = 1'b0, done = 1'b0;
  logic ev_ack, cmd_valid, sched_push, virt_inhib, virt_leak;
  logic [2:0] cmd_type, virt_weight;
  logic [7:0] cmd_hi, cmd_lo;
  logic [15:0] cmd_cycles;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  aer_event_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ev_addr(ev_addr), .ev_req(ev_req), .ev_ack(ev_ack),
    .done(done), .cmd_valid(cmd_valid), .sched_push(sched_push), .cmd_type(cmd_type),
    .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .virt_weight(virt_weight), .virt_inhib(virt_inhib),
    .virt_leak(virt_leak), .cmd_cycles(cmd_cycles)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] kind(input logic [16:0] a);
    if (a[16]) return 3'd0;
    case (a[7:0])
      8'hFF: return 3'd1;
      8'h7F: return 3'd2;
      8'h80: return 3'd3;
      8'h00: return 3'd4;
      8'h07: return 3'd5;
      default: return (a[2:0] == 3'b001) ? 3'd6 : 3'd7;
    endcase
  endfunction

  function automatic logic [15:0] cyc(input logic [2:0] k);
    case (k)
      3'd0, 3'd1: return 16'd2;
      3'd2: return 16'd512;
      3'd3: return 16'd128;
      3'd4: return 16'd32768;
      3'd5, 3'd6: return 16'd1;
      default: return 16'd0;
    endcase
  endfunction

  task automatic run_ev(input logic [16:0] a);
    logic [2:0] k;
    k = kind(a);
    @(negedge clk);
    ev_addr = a;
    ev_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 early valid", {cmd_valid, ev_ack}, 0);
    @(negedge clk);
    if (k == 3'd7) begin
      chk("R7 drop ack", {cmd_valid, ev_ack}, 2'b01);
      chk("R7 drop type", cmd_type, 7);
      chk("R7 drop cycles", cmd_cycles, 0);
    end else begin
      chk("R1 valid latency", cmd_valid, 1);
      chk(k == 0 ? "R2 type" : k < 3 ? "R3 type" : k < 5 ? "R4 type" : k == 5 ? "R5 type" : "R6 type",
          cmd_type, k);
      chk(k == 0 ? "R2 cycles" : k < 3 ? "R3 cycles" : k < 5 ? "R4 cycles" : "R5 R6 cycles",
          cmd_cycles, cyc(k));
      chk(k == 0 ? "R2 fields" : "R3 fields", {cmd_hi, cmd_lo}, a[15:0]);
      chk("R5 R6 push", sched_push, (k == 5 || k == 6));
      if (k == 6) chk("R6 virtual fields", {virt_weight, virt_inhib, virt_leak}, a[7:3]);
      repeat (2) @(negedge clk);
      chk("R8 no ack before done", {cmd_valid, ev_ack}, 0);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk("R8 ack after done", ev_ack, 1);
    end
    repeat (3) @(negedge clk);
    chk("R9 ack held with req", {cmd_valid, ev_ack}, 2'b01);
    ev_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 ack before sync fall", ev_ack, 1);
    @(negedge clk);
    chk("R9 ack falls", ev_ack, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {ev_ack, cmd_valid, sched_push}, 0);
    chk("R10 reset type", cmd_type, 7);
    chk("R10 reset cycles", cmd_cycles, 0);
    rst_n = 1'b1;
    for (int b = 0; b < 256; b++) run_ev({1'b0, 8'(b * 37 + 5), 8'(b)});
    for (int i = 0; i < 12; i++) run_ev({1'b1, 8'(i * 23), 8'(255 - i * 21)});
    run_ev({1'b1, 8'h00, 8'h07});
    run_ev({1'b1, 8'hFF, 8'hFF});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule